// File: doc/BRIEF.md
# Prioritised Interrupt and Bus-Request Arbiter

This block sits beside a CPU core and decides which pending event the core services at the next boundary. It watches a bus-hold request, one non-maskable interrupt and three maskable interrupt requests. A bus-hold request can win at any machine-cycle end. Every other source can win only at an instruction end. When a source is chosen, the block issues a single-cycle grant that names the winner. Alongside the grant it drives the acknowledge-strobe pattern the core must produce for that source, and a fixed service address when the winner is the non-maskable interrupt.

The non-maskable input is captured on a falling edge and held until it is serviced. Request 0 is a plain active-low level. Requests 1 and 2 each take a two-bit trigger setting: active-low level, rising edge or falling edge. An edge is latched until its acknowledge clears it. A level is never latched. One interrupt-enable flag gates all maskable sources. The core sets and clears the flag with strobes, and the block clears it by itself whenever it accepts a maskable request. A status byte reports the sampled levels of the request 1 and request 2 pins.

Top module: `irq_arbiter`

## Requirements
- R1: During and straight after reset, grant_valid, ack_m1, ack_iorq and ie are 0, grant_src is 0, vector is 0 and pin_status is 8'hC0.
- R2: A high-to-low transition on nmi_n is latched. It is granted (grant_src 2) at the next instr_end whatever the state of ie, and it is granted once per falling edge, so a pin held low does not fire again.
- R3: When the non-maskable source is granted, vector equals 16'h0066. For every other grant it is 0.
- R4: If busreq_n is low at an instr_end or mcyc_end strobe, the bus is granted (grant_src 1) ahead of every interrupt. A latched non-maskable interrupt stays pending through that grant.
- R5: Request 0 (irq0_n low) is granted (grant_src 3) at instr_end only if ie is 1 and neither bus nor non-maskable is pending. Its grant asserts both ack_m1 and ack_iorq.
- R6: Grants of request 1 (grant_src 4) and request 2 (grant_src 5) assert neither ack_m1 nor ack_iorq. They are granted only when bus, non-maskable and request 0 are all inactive.
- R7: Trigger setting per request: 2'b00 or 2'b11 = active-low level, 2'b01 = rising edge, 2'b10 = falling edge. An edge in the selected direction is latched until granted, and an edge in the other direction is ignored.
- R8: Request 1 wins over request 2 when both are pending.
- R9: With ie at 0 no maskable request is granted. ie_set sets ie. ie_clr clears it, as does any maskable grant, and a clear wins over ie_set.
- R10: pin_status bit 6 holds irq1_n and bit 7 holds irq2_n as sampled at the previous clock edge. All other bits are 0.
- R11: A grant lasts one cycle and follows a strobe at the edge before it. mcyc_end alone grants only the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_n | input | 1 | Non-maskable interrupt pin, falling-edge sensitive |
| busreq_n | input | 1 | Bus-hold request, active low |
| irq0_n | input | 1 | Maskable request 0, active-low level |
| irq1_n | input | 1 | Maskable request 1 pin |
| irq2_n | input | 1 | Maskable request 2 pin |
| irq1_mode | input | 2 | Trigger setting for request 1 |
| irq2_mode | input | 2 | Trigger setting for request 2 |
| ie_set | input | 1 | Sets the interrupt-enable flag |
| ie_clr | input | 1 | Clears the interrupt-enable flag |
| instr_end | input | 1 | Instruction-boundary strobe from the core |
| mcyc_end | input | 1 | Machine-cycle-boundary strobe from the core |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_src | output | 3 | Winner: 0 none, 1 bus, 2 non-maskable, 3/4/5 request 0/1/2 |
| ack_m1 | output | 1 | Acknowledge cycle needs the opcode-fetch strobe |
| ack_iorq | output | 1 | Acknowledge cycle needs the I/O-request strobe |
| vector | output | 16 | Service address for a non-maskable grant |
| ie | output | 1 | Interrupt-enable flag |
| pin_status | output | 8 | Sampled levels of request 1 and 2 pins |

## Verification
The bench sweeps all 64 combinations of bus request, latched non-maskable edge, the three request levels and ie. It compares each grant with a priority chain written separately in the bench. A design that put the non-maskable above the bus, or let ie mask it, would pick the wrong source. A design that dropped a non-maskable edge that lost to the bus would miss the follow-up grant. The bench also fires wrong-direction edges, holds nmi_n low across two strobes and strobes mcyc_end alone. A design that latched the wrong edge, re-fired on a held level or granted interrupts at machine-cycle ends would grant when it should stay idle. A design that failed to clear ie after a maskable grant, or that swapped the acknowledge strobes between request 0 and requests 1 and 2, is caught by the ie and strobe checks after each grant.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_BUS  = 3'd1,
    SRC_NMI  = 3'd2,
    SRC_IRQ0 = 3'd3,
    SRC_IRQ1 = 3'd4,
    SRC_IRQ2 = 3'd5
  } src_e;

  typedef enum logic [1:0] {
    TRIG_LEVEL     = 2'b00,
    TRIG_RISE      = 2'b01,
    TRIG_FALL      = 2'b10,
    TRIG_LEVEL_ALT = 2'b11
  } trig_e;

  // level settings never latch
  function automatic logic is_level(logic [1:0] mode);
    return (mode == TRIG_LEVEL) || (mode == TRIG_LEVEL_ALT);
  endfunction

  // edge of the selected direction between two samples
  function automatic logic edge_hit(logic [1:0] mode, logic prev, logic cur);
    case (mode)
      TRIG_RISE: return ~prev & cur;
      TRIG_FALL: return prev & ~cur;
      default:   return 1'b0;
    endcase
  endfunction

  // fixed priority: bus, non-maskable, request 0, 1, 2
  function automatic src_e pick_src(logic instr, logic mcyc, logic bus,
                                    logic nmi, logic ie, logic r0,
                                    logic r1, logic r2);
    if ((instr || mcyc) && bus) return SRC_BUS;
    if (!instr)                 return SRC_NONE;
    if (nmi)                    return SRC_NMI;
    if (!ie)                    return SRC_NONE;
    if (r0)                     return SRC_IRQ0;
    if (r1)                     return SRC_IRQ1;
    if (r2)                     return SRC_IRQ2;
    return SRC_NONE;
  endfunction

  function automatic logic is_maskable(logic [2:0] s);
    return (s == SRC_IRQ0) || (s == SRC_IRQ1) || (s == SRC_IRQ2);
  endfunction

endpackage

// File: rtl/irq_trig_cell.sv
module irq_trig_cell
  import irq_arb_pkg::*;
#(
  parameter bit         PROGRAMMABLE = 1'b1,
  parameter logic [1:0] FIXED_MODE   = 2'b10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_n,
  input  logic [1:0] mode,
  input  logic       ack,
  output logic       req
);

  logic [1:0] eff_mode;
  logic       prev_q;
  logic       pend_q;
  logic       hit;
  logic       level_sel;

  assign eff_mode  = PROGRAMMABLE ? mode : FIXED_MODE;
  assign level_sel = is_level(eff_mode);
  assign hit       = edge_hit(eff_mode, prev_q, pin_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_n;
      if (level_sel) pend_q <= 1'b0;
      else           pend_q <= (pend_q & ~ack) | hit;
    end
  end

  assign req = level_sel ? ~pin_n : pend_q;

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_arb_pkg::*;
(
  input  logic       instr_end,
  input  logic       mcyc_end,
  input  logic       bus_req,
  input  logic       nmi_req,
  input  logic       ie,
  input  logic       r0,
  input  logic       r1,
  input  logic       r2,
  output logic [2:0] sel
);

  always_comb begin
    sel = pick_src(instr_end, mcyc_end, bus_req, nmi_req, ie, r0, r1, r2);
  end

endmodule

// File: rtl/irq_pin_snap.sv
module irq_pin_snap #(
  parameter int STAT_W   = 8,
  parameter int LVL1_BIT = 6,
  parameter int LVL2_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl1,
  input  logic              lvl2,
  output logic [STAT_W-1:0] status
);

  localparam logic [STAT_W-1:0] IDLE_VAL =
    (STAT_W'(1) << LVL1_BIT) | (STAT_W'(1) << LVL2_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= IDLE_VAL;
    end else begin
      status           <= '0;
      status[LVL1_BIT] <= lvl1;
      status[LVL2_BIT] <= lvl2;
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int              VEC_W    = 16,
  parameter logic [VEC_W-1:0] NMI_VEC = 16'h0066,
  parameter int              STAT_W   = 8,
  parameter int              LVL1_BIT = 6,
  parameter int              LVL2_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_n,
  input  logic              busreq_n,
  input  logic              irq0_n,
  input  logic              irq1_n,
  input  logic              irq2_n,
  input  logic [1:0]        irq1_mode,
  input  logic [1:0]        irq2_mode,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              instr_end,
  input  logic              mcyc_end,
  output logic              grant_valid,
  output logic [2:0]        grant_src,
  output logic              ack_m1,
  output logic              ack_iorq,
  output logic [VEC_W-1:0]  vector,
  output logic              ie,
  output logic [STAT_W-1:0] pin_status
);

  localparam int NUM_PROG = 2;

  // named internal events
  logic                     nmi_req;
  logic                     nmi_ack;
  logic [2:0]               sel;
  logic                     take;
  logic                     mask_take;
  logic [NUM_PROG-1:0]      prog_pin_n;
  logic [NUM_PROG-1:0][1:0] prog_mode;
  logic [NUM_PROG-1:0]      prog_req;
  logic [NUM_PROG-1:0]      prog_ack;
  logic                     ie_q;

  assign prog_pin_n = {irq2_n, irq1_n};
  assign prog_mode  = {irq2_mode, irq1_mode};

  irq_trig_cell #(
    .PROGRAMMABLE (1'b0),
    .FIXED_MODE   (TRIG_FALL)
  ) u_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (nmi_n),
    .mode  (2'b00),
    .ack   (nmi_ack),
    .req   (nmi_req)
  );

  for (genvar g = 0; g < NUM_PROG; g++) begin : g_prog
    irq_trig_cell #(
      .PROGRAMMABLE (1'b1),
      .FIXED_MODE   (TRIG_LEVEL)
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n (prog_pin_n[g]),
      .mode  (prog_mode[g]),
      .ack   (prog_ack[g]),
      .req   (prog_req[g])
    );
  end

  irq_prio_sel u_sel (
    .instr_end (instr_end),
    .mcyc_end  (mcyc_end),
    .bus_req   (~busreq_n),
    .nmi_req   (nmi_req),
    .ie        (ie_q),
    .r0        (~irq0_n),
    .r1        (prog_req[0]),
    .r2        (prog_req[1]),
    .sel       (sel)
  );

  assign take        = (sel != SRC_NONE);
  assign mask_take   = is_maskable(sel);
  assign nmi_ack     = (sel == SRC_NMI);
  assign prog_ack[0] = (sel == SRC_IRQ1);
  assign prog_ack[1] = (sel == SRC_IRQ2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_src   <= SRC_NONE;
      ack_m1      <= 1'b0;
      ack_iorq    <= 1'b0;
      vector      <= '0;
    end else begin
      grant_valid <= take;
      grant_src   <= sel;
      ack_m1      <= (sel == SRC_IRQ0);
      ack_iorq    <= (sel == SRC_IRQ0);
      vector      <= nmi_ack ? NMI_VEC : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 ie_q <= 1'b0;
    else if (mask_take || ie_clr) ie_q <= 1'b0;
    else if (ie_set)            ie_q <= 1'b1;
  end

  assign ie = ie_q;

  irq_pin_snap #(
    .STAT_W   (STAT_W),
    .LVL1_BIT (LVL1_BIT),
    .LVL2_BIT (LVL2_BIT)
  ) u_snap (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl1   (irq1_n),
    .lvl2   (irq2_n),
    .status (pin_status)
  );

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_arb_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int STAT_W   = 8,
  parameter int LVL1_BIT = 6,
  parameter int LVL2_BIT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busreq_n,
  input logic              irq1_n,
  input logic              irq2_n,
  input logic              instr_end,
  input logic              mcyc_end,
  input logic              grant_valid,
  input logic [2:0]        grant_src,
  input logic              ack_m1,
  input logic              ack_iorq,
  input logic [VEC_W-1:0]  vector,
  input logic              ie,
  input logic [STAT_W-1:0] pin_status
);

  logic started;
  always_ff @(posedge clk) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R11: grant pulse and source agree
  p_src_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant_src != SRC_NONE));

  // R11: a grant follows a strobe
  p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (started && grant_valid) |-> $past(instr_end || mcyc_end));

  // R11: machine-cycle end alone yields only the bus
  p_mcyc_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(mcyc_end && !instr_end) && grant_valid) |-> grant_src == SRC_BUS);

  // R4: bus request wins at any strobe
  p_bus_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(!busreq_n && (instr_end || mcyc_end))) |-> grant_src == SRC_BUS);

  // R3: service address for the non-maskable grant
  p_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_src == SRC_NMI) |-> vector == VEC_W'(16'h0066));

  // R5: request 0 takes both strobes
  p_ack0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_src == SRC_IRQ0) |-> (ack_m1 && ack_iorq));

  // R6: requests 1 and 2 take neither strobe
  p_ack12_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_src == SRC_IRQ1 || grant_src == SRC_IRQ2) |-> (!ack_m1 && !ack_iorq));

  // R9: maskable grant needs ie and clears it
  p_ie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (started && is_maskable(grant_src)) |-> (!ie && $past(ie)));

  // R10: status bits follow the pins one edge later
  p_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (pin_status[LVL1_BIT] == $past(irq1_n) &&
                 pin_status[LVL2_BIT] == $past(irq2_n)));

endmodule

bind irq_arbiter irq_arbiter_chk #(
  .VEC_W    (VEC_W),
  .STAT_W   (STAT_W),
  .LVL1_BIT (LVL1_BIT),
  .LVL2_BIT (LVL2_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busreq_n    (busreq_n),
  .irq1_n      (irq1_n),
  .irq2_n      (irq2_n),
  .instr_end   (instr_end),
  .mcyc_end    (mcyc_end),
  .grant_valid (grant_valid),
  .grant_src   (grant_src),
  .ack_m1      (ack_m1),
  .ack_iorq    (ack_iorq),
  .vector      (vector),
  .ie          (ie),
  .pin_status  (pin_status)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_n, busreq_n, irq0_n, irq1_n, irq2_n;
  logic [1:0]  irq1_mode, irq2_mode;
  logic        ie_set, ie_clr, instr_end, mcyc_end;
  logic        grant_valid;
  logic [2:0]  grant_src;
  logic        ack_m1, ack_iorq;
  logic [15:0] vector;
  logic        ie;
  logic [7:0]  pin_status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .busreq_n(busreq_n),
    .irq0_n(irq0_n), .irq1_n(irq1_n), .irq2_n(irq2_n),
    .irq1_mode(irq1_mode), .irq2_mode(irq2_mode),
    .ie_set(ie_set), .ie_clr(ie_clr), .instr_end(instr_end), .mcyc_end(mcyc_end),
    .grant_valid(grant_valid), .grant_src(grant_src), .ack_m1(ack_m1),
    .ack_iorq(ack_iorq), .vector(vector), .ie(ie), .pin_status(pin_status)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one instr_end (or mcyc_end) strobe, returns at the cycle showing the grant
  task automatic strobe(bit ins, bit mc);
    instr_end = ins;
    mcyc_end  = mc;
    tick();
    instr_end = 1'b0;
    mcyc_end  = 1'b0;
  endtask

  task automatic set_ie(bit v);
    if (v) ie_set = 1'b1; else ie_clr = 1'b1;
    tick();
    ie_set = 1'b0;
    ie_clr = 1'b0;
  endtask

  // bench-side priority: bus over nmi over enabled 0, 1, 2
  function automatic logic [2:0] model(bit b, bit n, bit e, bit z, bit a, bit c);
    logic [2:0] r;
    r = 3'd0;
    if (!e) r = 3'd0;
    else if (c) r = 3'd5;
    if (e && a) r = 3'd4;
    if (e && z) r = 3'd3;
    if (n) r = 3'd2;
    if (b) r = 3'd1;
    return r;
  endfunction

  task automatic grant_is(string req, logic [2:0] exp);
    chk(req, "grant_src", grant_src, exp);
    chk(req, "grant_valid", grant_valid, exp != 3'd0);
    chk("R5", "ack_m1", ack_m1, exp == 3'd3);
    chk("R6", "ack_iorq", ack_iorq, exp == 3'd3);
    chk("R3", "vector", vector, (exp == 3'd2) ? 32'h66 : 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R11 actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; nmi_n = 1'b1; busreq_n = 1'b1; irq0_n = 1'b1;
    irq1_n = 1'b1; irq2_n = 1'b1; irq1_mode = 2'b00; irq2_mode = 2'b00;
    ie_set = 1'b0; ie_clr = 1'b0; instr_end = 1'b0; mcyc_end = 1'b0;
    repeat (3) tick();
    // R1 reset state
    chk("R1", "grant_valid", grant_valid, 0);
    chk("R1", "grant_src", grant_src, 0);
    chk("R1", "ack", {ack_m1, ack_iorq}, 0);
    chk("R1", "ie", ie, 0);
    chk("R1", "vector", vector, 0);
    chk("R1", "pin_status", pin_status, 8'hC0);
    rst_n = 1'b1;
    tick();
    chk("R1", "grant_after", grant_valid, 0);

    // sweep over bus, nmi edge, ie and three levels (R2 R4 R5 R6 R8 R9 R10)
    for (int i = 0; i < 64; i++) begin
      bit b, n, z, a, c, e;
      b = i[0]; n = i[1]; z = i[2]; a = i[3]; c = i[4]; e = i[5];
      set_ie(e);
      if (n) begin nmi_n = 1'b0; tick(); end
      busreq_n = ~b; irq0_n = ~z; irq1_n = ~a; irq2_n = ~c;
      strobe(1'b1, 1'b0);
      grant_is("R8", model(b, n, e, z, a, c));
      chk("R10", "pin_status", pin_status, {~c, ~a, 6'b0});
      if (model(b, n, e, z, a, c) >= 3'd3) chk("R9", "ie_cleared", ie, 0);
      busreq_n = 1'b1; irq0_n = 1'b1; irq1_n = 1'b1; irq2_n = 1'b1; nmi_n = 1'b1;
      strobe(1'b1, 1'b0);
      grant_is("R4", (n && b) ? 3'd2 : 3'd0);
    end

    // R2: held-low nmi fires once
    nmi_n = 1'b1; tick(); nmi_n = 1'b0; tick();
    strobe(1'b1, 1'b0);
    grant_is("R2", 3'd2);
    strobe(1'b1, 1'b0);
    grant_is("R2", 3'd0);
    nmi_n = 1'b1; tick();

    // R11: mcyc_end alone does not serve nmi; bus at mcyc_end
    nmi_n = 1'b0; tick(); nmi_n = 1'b1;
    strobe(1'b0, 1'b1);
    grant_is("R11", 3'd0);
    busreq_n = 1'b0;
    strobe(1'b0, 1'b1);
    grant_is("R4", 3'd1);
    busreq_n = 1'b1;
    strobe(1'b1, 1'b0);
    grant_is("R2", 3'd2);

    // R7: rising edge on request 1 latched until granted
    irq1_mode = 2'b01; irq1_n = 1'b0; tick(); tick();
    irq1_n = 1'b1; tick();
    set_ie(1'b1);
    strobe(1'b1, 1'b0);
    grant_is("R7", 3'd4);
    set_ie(1'b1);
    strobe(1'b1, 1'b0);
    grant_is("R7", 3'd0);
    chk("R7", "ie_kept", ie, 1);

    // R7: falling edge on request 2
    irq2_mode = 2'b10; irq2_n = 1'b0; tick(); irq2_n = 1'b1; tick();
    strobe(1'b1, 1'b0);
    grant_is("R7", 3'd5);
    // R7: wrong-direction edge ignored
    irq2_mode = 2'b01; set_ie(1'b1);
    irq2_n = 1'b0; tick(); tick();
    strobe(1'b1, 1'b0);
    grant_is("R7", 3'd0);
    irq2_n = 1'b1;
    // R7: mode 11 acts as level
    irq2_mode = 2'b11; tick();
    irq2_n = 1'b0;
    strobe(1'b1, 1'b0);
    grant_is("R7", 3'd5);
    irq2_n = 1'b1; tick();

    // R9: ie_clr wins over ie_set
    ie_set = 1'b1; ie_clr = 1'b1; tick(); ie_set = 1'b0; ie_clr = 1'b0;
    chk("R9", "clr_wins", ie, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule